// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits behind a serial receive shifter and buffers incoming characters for a host. Each character arrives with its parity, framing and break flags already computed. The block stores the character together with its flags in a queue that is 16 entries deep by default. The head of the queue is shown on the data output, and the host removes it with a pop strobe. The block also builds the 8-bit line status byte from the queue state, the head character's flags and two flags from the transmitter. From the same state it raises two interrupt requests: one when enough data is available, and one when characters have sat in the queue with no activity.

The host configures the queue with writes of a FIFO control byte. Bit 0 turns the queue on. Bit 1 empties the receive queue. Bit 2 asks the transmitter to empty its own queue, which this block signals on a one-cycle flush output. Bits 7:6 pick the receive threshold. Any change of bit 0 empties both queues. With the queue off, the block behaves as a single holding register.

Top module: `rxq_top`

## Requirements
- R1: Characters are presented on `rxByte` in arrival order, one entry is removed per accepted pop, and at most DEPTH characters are held. `rxByte` reads 0 while the queue is empty.
- R2: While the queue holds a character, `lineStatus` bit 2 shows the head character's parity error, bit 3 its framing error and bit 4 its break flag.
- R3: A character that arrives while the queue is full, with no pop in the same cycle, is dropped. `lineStatus` bit 1 (overrun) is set and the stored characters are unchanged.
- R4: `lineStatus` bit 0 is 1 exactly when the queue is non-empty. Bits 5 and 6 mirror `thrEmpty` and `txIdle`. A `lsrRead` strobe clears bits 1 to 4 and bit 7 from the next cycle onward, until a new event sets them again.
- R5: `lineStatus` bit 7 is set when a character with any error flag is accepted into the queue. It is cleared by a line status read or by a receive flush.
- R6: With the queue on, `dataAvailIrq` is high while the fill level is at least the threshold chosen by FIFO control bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8, and 11 gives 14.
- R7: With the queue on and non-empty, `timeoutIrq` rises on the baud tick that completes 4×`frameBits` ticks without a push or a pop. A pop or a flush clears it.
- R8: A FIFO control write that changes bit 0, or that has bit 1 set, empties the receive queue. A write that changes bit 0, or that has bit 2 set, drives `txFlush` high for the following cycle.
- R9: With the queue off, capacity is one character, a second arrival is an overrun, and `dataAvailIrq` is high whenever a character is held, whatever threshold is stored.
- R10: A pop while the queue is empty has no effect. A character that arrives in the same cycle as a receive flush is discarded without an overrun.
- R11: After reset the queue is off and empty, all status flags are clear, and both interrupts and `txFlush` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Strobe: a received character is presented |
| rxData | input | 8 | Received character |
| rxParErr | input | 1 | Parity error flag for the character |
| rxFrmErr | input | 1 | Framing error flag for the character |
| rxBreak | input | 1 | Break flag for the character |
| popReq | input | 1 | Host reads and removes the head character |
| lsrRead | input | 1 | Host reads the line status byte |
| fcrWrite | input | 1 | Strobe: write the FIFO control byte |
| fcrData | input | 8 | FIFO control byte |
| baudTick | input | 1 | One pulse per bit time |
| frameBits | input | FRAME_W | Configured bits per character frame |
| thrEmpty | input | 1 | Transmitter holding register is empty |
| txIdle | input | 1 | Transmitter is fully empty |
| rxByte | output | 8 | Head character |
| lineStatus | output | 8 | Line status byte |
| dataAvailIrq | output | 1 | Threshold data-available request |
| timeoutIrq | output | 1 | Character timeout request |
| txFlush | output | 1 | One-cycle request to empty the transmit queue |

## Verification
Every status output comes from registers without further delay. A push, pop, line status read or control write therefore shows its effect right after the clock edge that samples it. `txFlush` is registered, so it is high for exactly the cycle after the control write. The timeout appears on the edge of the 4×`frameBits`-th baud tick. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands one edge after its stimulus. The timeout test checks the tick before the deadline as well as the deadline tick itself.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } qStrobe_t;

  function automatic int trigLevel(logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qStrobe_t         strb,
  input  rxEntry_t         wrEntry,
  output rxEntry_t         headEntry,
  output logic [CNT_W-1:0] count
);

  rxEntry_t mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headEntry = mem[rdPtr];

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R10
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> count != '0);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IDLE_W = FRAME_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxValid,
  input  logic               rxParErr,
  input  logic               rxFrmErr,
  input  logic               rxBreak,
  input  logic               popReq,
  input  logic               lsrRead,
  input  logic               fcrWrite,
  input  logic [7:0]         fcrData,
  input  logic               baudTick,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               thrEmpty,
  input  logic               txIdle,
  input  logic [CNT_W-1:0]   count,
  input  rxEntry_t           headEntry,
  output qStrobe_t           strb,
  output logic [7:0]         rxByte,
  output logic [7:0]         lineStatus,
  output logic               dataAvailIrq,
  output logic               timeoutIrq,
  output logic               txFlush
);

  logic fifoEn, ovrFlag, errSticky, headHidden, tmoFlag, txFlushQ;
  logic [1:0] trigCode;
  logic [IDLE_W-1:0] idleCnt, idleLimit;
  logic [CNT_W-1:0] capacity, trigCount;
  logic empty, full, flushNow, popOk, pushOk, ovrSet, errIn, enChange;

  always_comb begin
    empty     = (count == '0);
    capacity  = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
    full      = (count >= capacity);
    enChange  = fcrWrite && (fcrData[0] != fifoEn);
    flushNow  = enChange || (fcrWrite && fcrData[1]);
    popOk     = popReq && !empty && !flushNow;
    pushOk    = rxValid && !flushNow && (!full || popOk);
    ovrSet    = rxValid && !flushNow && full && !popOk;
    errIn     = rxParErr | rxFrmErr | rxBreak;
    idleLimit = {frameBits, 2'b00};
    trigCount = CNT_W'(trigLevel(trigCode));
  end

  assign strb.push  = pushOk;
  assign strb.pop   = popOk;
  assign strb.flush = flushNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifoEn     <= 1'b0;
      trigCode   <= 2'b00;
      ovrFlag    <= 1'b0;
      errSticky  <= 1'b0;
      headHidden <= 1'b0;
      tmoFlag    <= 1'b0;
      txFlushQ   <= 1'b0;
      idleCnt    <= '0;
    end else begin
      if (fcrWrite) begin
        fifoEn   <= fcrData[0];
        trigCode <= fcrData[7:6];
      end
      txFlushQ <= enChange || (fcrWrite && fcrData[2]);

      if (ovrSet)       ovrFlag <= 1'b1;
      else if (lsrRead) ovrFlag <= 1'b0;

      if (pushOk && errIn)          errSticky <= 1'b1;
      else if (lsrRead || flushNow) errSticky <= 1'b0;

      if (popOk || flushNow || (pushOk && empty)) headHidden <= 1'b0;
      else if (lsrRead)                           headHidden <= 1'b1;

      if (pushOk || popOk || flushNow || empty || !fifoEn)
        idleCnt <= '0;
      else if (baudTick && !tmoFlag)
        idleCnt <= idleCnt + IDLE_W'(1);

      if (popOk || flushNow || !fifoEn)
        tmoFlag <= 1'b0;
      else if (!empty && !pushOk && baudTick && !tmoFlag &&
               (idleCnt + IDLE_W'(1) == idleLimit))
        tmoFlag <= 1'b1;
    end
  end

  logic showFlags;
  assign showFlags    = !empty && !headHidden;
  assign rxByte       = empty ? 8'h00 : headEntry.data;
  assign lineStatus   = {errSticky, txIdle, thrEmpty,
                         showFlags & headEntry.brk,
                         showFlags & headEntry.frm,
                         showFlags & headEntry.par,
                         ovrFlag, !empty};
  assign dataAvailIrq = fifoEn ? (count >= trigCount) : !empty;
  assign timeoutIrq   = tmoFlag;
  assign txFlush      = txFlushQ;

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && !fcrWrite && !popReq && count == CNT_W'(DEPTH)) |=> (ovrFlag && $stable(count)));

  // R4
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsrRead && !rxValid) |=> !ovrFlag);

  // R7
  tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmoFlag |-> count != '0);

  // R8
  txflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcrWrite && fcrData[2]) |=> txFlush);

  // R9
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoEn |-> count <= CNT_W'(1));

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxValid,
  input  logic [7:0]         rxData,
  input  logic               rxParErr,
  input  logic               rxFrmErr,
  input  logic               rxBreak,
  input  logic               popReq,
  input  logic               lsrRead,
  input  logic               fcrWrite,
  input  logic [7:0]         fcrData,
  input  logic               baudTick,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               thrEmpty,
  input  logic               txIdle,
  output logic [7:0]         rxByte,
  output logic [7:0]         lineStatus,
  output logic               dataAvailIrq,
  output logic               timeoutIrq,
  output logic               txFlush
);

  qStrobe_t strb;
  rxEntry_t wrEntry, headEntry;
  logic [CNT_W-1:0] count;

  assign wrEntry = '{brk: rxBreak, frm: rxFrmErr, par: rxParErr, data: rxData};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrEntry(wrEntry),
    .headEntry(headEntry), .count(count)
  );

  rxq_ctrl #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBreak(rxBreak), .popReq(popReq),
    .lsrRead(lsrRead), .fcrWrite(fcrWrite), .fcrData(fcrData),
    .baudTick(baudTick), .frameBits(frameBits), .thrEmpty(thrEmpty),
    .txIdle(txIdle), .count(count), .headEntry(headEntry), .strb(strb),
    .rxByte(rxByte), .lineStatus(lineStatus), .dataAvailIrq(dataAvailIrq),
    .timeoutIrq(timeoutIrq), .txFlush(txFlush)
  );

endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;

  localparam int CLK_NS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxValid = 0, rxParErr = 0, rxFrmErr = 0, rxBreak = 0;
  logic [7:0] rxData = '0;
  logic popReq = 0, lsrRead = 0, fcrWrite = 0, baudTick = 0;
  logic [7:0] fcrData = '0;
  logic [3:0] frameBits = 4'd10;
  logic thrEmpty = 1, txIdle = 1;
  logic [7:0] rxByte, lineStatus;
  logic dataAvailIrq, timeoutIrq, txFlush;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  rxq_top dut (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxBreak(rxBreak),
    .popReq(popReq), .lsrRead(lsrRead), .fcrWrite(fcrWrite),
    .fcrData(fcrData), .baudTick(baudTick), .frameBits(frameBits),
    .thrEmpty(thrEmpty), .txIdle(txIdle), .rxByte(rxByte),
    .lineStatus(lineStatus), .dataAvailIrq(dataAvailIrq),
    .timeoutIrq(timeoutIrq), .txFlush(txFlush)
  );

  // [7:0] data, [8] parity, [9] framing, [10] break, [15:11] expected status bits 4:0
  localparam logic [15:0] VEC [6] = '{
    {5'b00001, 3'b000, 8'hA5},
    {5'b00101, 3'b001, 8'h3C},
    {5'b01001, 3'b010, 8'h0F},
    {5'b11001, 3'b110, 8'hF0},
    {5'b00001, 3'b000, 8'h81},
    {5'b00101, 3'b001, 8'h7E}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushChar(input logic [7:0] d, input logic p, input logic f, input logic b);
    rxValid = 1; rxData = d; rxParErr = p; rxFrmErr = f; rxBreak = b;
    step();
    rxValid = 0; rxParErr = 0; rxFrmErr = 0; rxBreak = 0;
  endtask

  task automatic popOne();
    popReq = 1; step(); popReq = 0;
  endtask

  task automatic readLsr();
    lsrRead = 1; step(); lsrRead = 0;
  endtask

  task automatic writeFcr(input logic [7:0] v);
    fcrWrite = 1; fcrData = v; step(); fcrWrite = 0;
  endtask

  task automatic tick();
    baudTick = 1; step(); baudTick = 0;
  endtask

  function automatic int lvlOf(int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk("R11 status after reset", lineStatus, 8'h60);
    chk("R11 data irq after reset", dataAvailIrq, 0);
    chk("R11 timeout after reset", timeoutIrq, 0);
    chk("R11 txFlush after reset", txFlush, 0);
    thrEmpty = 1; txIdle = 0; step();
    chk("R4 tx flags mirrored", lineStatus[6:5], 2'b01);
    txIdle = 1;

    // Vector table: ordering and per-entry flags
    writeFcr(8'h03);
    foreach (VEC[i]) pushChar(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10]);
    chk("R5 error summary set", lineStatus[7], 1);
    foreach (VEC[i]) begin
      chk("R1 head data order", rxByte, VEC[i][7:0]);
      chk("R2 head flags", lineStatus[4:0], VEC[i][15:11]);
      popOne();
    end
    chk("R4 ready cleared when empty", lineStatus[0], 0);
    chk("R1 empty reads zero", rxByte, 8'h00);

    // R6 threshold per code
    for (int c = 0; c < 4; c++) begin
      writeFcr({c[1:0], 3'b000, 3'b011});
      for (int j = 0; j < lvlOf(c) - 1; j++) pushChar(8'(j), 0, 0, 0);
      chk("R6 below threshold", dataAvailIrq, 0);
      pushChar(8'hAA, 0, 0, 0);
      chk("R6 at threshold", dataAvailIrq, 1);
    end

    // R3 overrun at full
    writeFcr(8'h03);
    for (int i = 0; i < 16; i++) pushChar(8'h10 + 8'(i), 0, 0, 0);
    chk("R3 no overrun at 16", lineStatus[1], 0);
    pushChar(8'hEE, 0, 0, 0);
    chk("R3 overrun flagged", lineStatus[1], 1);
    readLsr();
    chk("R4 overrun cleared by read", lineStatus[1], 0);
    for (int i = 0; i < 16; i++) begin
      chk("R3 stored data kept", rxByte, 8'h10 + 8'(i));
      popOne();
    end
    chk("R3 dropped char absent", lineStatus[0], 0);

    // R4/R5 read clears head flags and summary
    pushChar(8'h5A, 1, 0, 0);
    chk("R2 parity shown", lineStatus[2], 1);
    chk("R5 summary shown", lineStatus[7], 1);
    readLsr();
    chk("R4 parity cleared by read", lineStatus[2], 0);
    chk("R5 summary cleared by read", lineStatus[7], 0);
    chk("R4 ready kept after read", lineStatus[0], 1);
    popOne();

    // R7 timeout: 4*10 ticks
    frameBits = 4'd10;
    pushChar(8'h77, 0, 0, 0);
    for (int i = 0; i < 39; i++) tick();
    chk("R7 no timeout before deadline", timeoutIrq, 0);
    tick();
    chk("R7 timeout at deadline", timeoutIrq, 1);
    popOne();
    chk("R7 pop clears timeout", timeoutIrq, 0);

    // R10 empty pop and flush vs push
    popOne();
    chk("R10 empty pop ignored", lineStatus[0], 0);
    pushChar(8'h55, 0, 0, 0);
    chk("R10 data intact after empty pop", rxByte, 8'h55);
    rxValid = 1; rxData = 8'h66; fcrWrite = 1; fcrData = 8'h03;
    step();
    rxValid = 0; fcrWrite = 0;
    chk("R10 flush beats push", lineStatus[0], 0);
    chk("R10 no overrun on flush", lineStatus[1], 0);

    // R8 enable toggle flushes both
    pushChar(8'h01, 0, 0, 0); pushChar(8'h02, 0, 0, 0); pushChar(8'h03, 0, 0, 0);
    writeFcr(8'h00);
    chk("R8 toggle empties rx", lineStatus[0], 0);
    chk("R8 toggle pulses txFlush", txFlush, 1);
    step();
    chk("R8 txFlush one cycle", txFlush, 0);
    pushChar(8'h42, 0, 0, 0);
    writeFcr(8'h04);
    chk("R8 bit2 pulses txFlush", txFlush, 1);
    chk("R8 bit2 keeps rx", rxByte, 8'h42);

    // R9 single holding register
    writeFcr(8'hC0);
    chk("R9 data irq at one char", dataAvailIrq, 1);
    pushChar(8'h99, 0, 0, 0);
    chk("R9 second char overruns", lineStatus[1], 1);
    chk("R9 first char kept", rxByte, 8'h42);
    popOne();
    chk("R9 only one held", lineStatus[0], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule